// File: doc/BRIEF.md
# Debounced keypad matrix scanner

This block scans a switch matrix of `ROWS` rows by `COLS` columns (8 by 10 by default, 80 switches) and turns the switch activity into a stream of key events. It pulls one row line low at a time and reads the column lines, which idle high through pull-ups. A column reads low when a closed switch joins it to the active row. A key changes its reported state only when two scan passes, one scan period apart, agree on the new level. This removes contact bounce and short glitches without a counter for each switch.

The scan period is set in clock cycles from the clock rate parameter `CLK_HZ` and the period parameter `SCAN_US`. The default is 25 ms, and a simulation can use a much shorter period. When no key is held and no change is pending, the scanner rests: it drives every row low and waits for any column to go low. Each event is one byte. The top bit gives the direction (1 for press, 0 for release), and the low bits hold the key code `row*COLS + col + 1`. Events leave through a valid/ready push port to a downstream queue. `push_valid` stays high and `push_data` does not change until the cycle in which `push_ready` is also high. While events from one scan are still waiting to be accepted, no new scan starts, so back-pressure delays detection and never drops an event.

Top module: `kpd_scanner`

## Requirements
- R1: While the scanner is active, at most one row line is low at any time. During a scan, each row is held low for `ROW_CYC` cycles in turn from row 0 to row `ROWS-1`. Between scans, all rows are high.
- R2: With no key held and no change pending, the scanner rests with every row output low. When a column goes low during rest, a scan starts within a few cycles.
- R3: A press is reported only after two scans one period apart both see the switch closed. From a resting scanner, the press event appears no sooner than one scan period after the switch closes, and no later than two periods plus one scan time plus 8 cycles.
- R4: A closure shorter than the scan period minus the time of one scan produces no event.
- R5: A release is reported only after two scans one period apart both see the switch open. The release event appears no sooner than one scan period after the switch opens, and no later than two periods plus one scan time plus 8 cycles.
- R6: Bits 6:0 of an event byte hold the key code row*COLS+col+1, where row and col count from 0. Bit 7 is 1 for a press and 0 for a release. Row 0, column 0 gives code 1, row 1, column 1 gives code 12, and row 4, column 4 gives code 45.
- R7: When several keys change in the same scan, their events leave in ascending key-code order, one per cycle while `push_ready` is high. Presses and releases are mixed in that order.
- R8: While `push_valid` is high and `push_ready` is low, `push_data` holds its value. No scan is taken while events are waiting, so no event is lost.
- R9: After reset, `push_valid` is low.
- R10: A key that stays held gives exactly one press event, however many scans pass. After all keys are released and the release events are accepted, the scanner returns to rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_n | output | ROWS | Row drive lines, active low |
| col_n | input | COLS | Column sense lines, pulled up, low when a switch is closed on a low row |
| push_valid | output | 1 | An event is offered |
| push_ready | input | 1 | The downstream queue accepts the offered event |
| push_data | output | KEY_W+1 (8) | Event byte: direction flag in the top bit, key code below it |

## Verification
Two of the block's functions can be confirmed in one scan: the press of one key and the release of another. When that happens they form one batch, and the emitter must order that batch by key code while keeping each event's flag. The bench waits until the rows show the gap between scans. It then releases one held key and closes another in the same cycle, so that both changes are sampled by the same two scans. The result is judged as correct only if the release and the press come out in ascending code order, with the right flag bits, on adjacent clock cycles. A second collision is also tested: a new scan comes due while a batch is stalled by back-pressure. This is provoked by holding `push_ready` low across several periods. The test is judged by the held byte staying unchanged and by every release arriving once the port is freed.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_SCAN = 2'd2,
    SQ_DONE = 2'd3
  } seq_state_t;

endpackage

// File: rtl/kpd_seq.sv
module kpd_seq #(
  parameter int ROWS        = 8,
  parameter int COLS        = 10,
  parameter int ROW_CYC     = 2,
  parameter int PERIOD_CLKS = 48,
  localparam int NKEYS  = ROWS * COLS,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SLOT_W = (ROW_CYC > 1) ? $clog2(ROW_CYC) : 1,
  localparam int PER_W  = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COLS-1:0]  col_n,
  input  logic             busy,
  input  logic             quiet,
  output logic [ROWS-1:0]  row_n,
  output logic [NKEYS-1:0] raw,
  output logic             scan_done,
  output logic             idle
);
  import kpd_pkg::*;

  seq_state_t        st;
  logic [PER_W-1:0]  per_cnt;
  logic              due;
  logic [ROW_W-1:0]  row_idx;
  logic [SLOT_W-1:0] slot;
  logic [COLS-1:0]   col_q;
  logic [NKEYS-1:0]  raw_q;
  logic              roll;

  assign roll      = (st != SQ_IDLE) && (per_cnt == PER_W'(PERIOD_CLKS - 1));
  assign raw       = raw_q;
  assign scan_done = (st == SQ_DONE);
  assign idle      = (st == SQ_IDLE);

  always_comb begin
    row_n = '1;
    if (st == SQ_IDLE) row_n = '0;
    else if (st == SQ_SCAN) row_n[row_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      per_cnt <= '0;
      due     <= 1'b0;
      row_idx <= '0;
      slot    <= '0;
      col_q   <= '1;
      raw_q   <= '0;
    end else begin
      col_q <= col_n;
      if (st == SQ_IDLE) begin
        per_cnt <= '0;
        due     <= 1'b0;
      end else begin
        per_cnt <= roll ? '0 : per_cnt + 1'b1;
        if (roll) due <= 1'b1;
      end
      case (st)
        SQ_IDLE: if (!busy && (col_q != '1)) begin
          st      <= SQ_SCAN;
          row_idx <= '0;
          slot    <= '0;
        end
        SQ_WAIT: if (due && !busy) begin
          st      <= SQ_SCAN;
          row_idx <= '0;
          slot    <= '0;
          due     <= roll;
        end
        SQ_SCAN: begin
          if (slot == SLOT_W'(ROW_CYC - 1)) begin
            slot <= '0;
            raw_q[row_idx*COLS +: COLS] <= ~col_n;
            if (row_idx == ROW_W'(ROWS - 1)) st <= SQ_DONE;
            else row_idx <= row_idx + 1'b1;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        SQ_DONE: st <= quiet ? SQ_IDLE : SQ_WAIT;
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/kpd_filter.sv
module kpd_filter #(
  parameter int NKEYS = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_done,
  input  logic [NKEYS-1:0] raw,
  output logic [NKEYS-1:0] level_next,
  output logic [NKEYS-1:0] change,
  output logic             quiet
);
  logic [NKEYS-1:0] prev_q;
  logic [NKEYS-1:0] level_q;
  logic [NKEYS-1:0] agree;

  // A key takes a new level only when two consecutive scans agree on it.
  assign agree      = ~(raw ^ prev_q);
  assign level_next = (agree & raw) | (~agree & level_q);
  assign change     = level_next ^ level_q;
  assign quiet      = (level_next == '0) && (raw == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      level_q <= '0;
    end else if (scan_done) begin
      prev_q  <= raw;
      level_q <= level_next;
    end
  end

endmodule

// File: rtl/kpd_emit.sv
module kpd_emit #(
  parameter int NKEYS = 80,
  parameter int KEY_W = 7,
  localparam int IDX_W = (NKEYS > 1) ? $clog2(NKEYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NKEYS-1:0] change,
  input  logic [NKEYS-1:0] level,
  output logic             push_valid,
  input  logic             push_ready,
  output logic [KEY_W:0]   push_data,
  output logic             busy
);
  logic [NKEYS-1:0] pend_q;
  logic [NKEYS-1:0] snap_q;
  logic [IDX_W-1:0] sel;

  // Lowest pending index wins, giving ascending key codes.
  always_comb begin
    sel = '0;
    for (int i = NKEYS - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = IDX_W'(i);
    end
  end

  assign busy       = |pend_q;
  assign push_valid = busy;
  assign push_data  = {snap_q[sel], KEY_W'(sel) + KEY_W'(1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      snap_q <= '0;
    end else if (load) begin
      pend_q <= change;
      snap_q <= level;
    end else if (push_valid && push_ready) begin
      pend_q[sel] <= 1'b0;
    end
  end

endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner #(
  parameter int ROWS    = 8,
  parameter int COLS    = 10,
  parameter int ROW_CYC = 2,
  parameter int CLK_HZ  = 50_000_000,
  parameter int SCAN_US = 25_000,
  localparam int NKEYS       = ROWS * COLS,
  localparam int KEY_W       = $clog2(NKEYS + 1),
  localparam int PERIOD_CLKS = (CLK_HZ / 1_000_000) * SCAN_US
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [ROWS-1:0] row_n,
  input  logic [COLS-1:0] col_n,
  output logic            push_valid,
  input  logic            push_ready,
  output logic [KEY_W:0]  push_data
);
  logic [NKEYS-1:0] raw;
  logic [NKEYS-1:0] level_next;
  logic [NKEYS-1:0] change;
  logic             quiet;
  logic             scan_done;
  logic             seq_idle;
  logic             emit_busy;

  kpd_seq #(
    .ROWS(ROWS), .COLS(COLS), .ROW_CYC(ROW_CYC), .PERIOD_CLKS(PERIOD_CLKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .col_n(col_n), .busy(emit_busy), .quiet(quiet),
    .row_n(row_n), .raw(raw), .scan_done(scan_done), .idle(seq_idle)
  );

  kpd_filter #(.NKEYS(NKEYS)) u_filter (
    .clk(clk), .rst_n(rst_n), .scan_done(scan_done), .raw(raw),
    .level_next(level_next), .change(change), .quiet(quiet)
  );

  kpd_emit #(.NKEYS(NKEYS), .KEY_W(KEY_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .load(scan_done), .change(change), .level(level_next),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .busy(emit_busy)
  );

endmodule

// File: rtl/kpd_scanner_chk.sv
module kpd_scanner_chk #(
  parameter int ROWS  = 8,
  parameter int COLS  = 10,
  parameter int KEY_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ROWS-1:0] row_n,
  input logic            push_valid,
  input logic            push_ready,
  input logic [KEY_W:0]  push_data,
  input logic            idle,
  input logic            busy,
  input logic            scan_done
);

  p_one_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> ($countones(~row_n) <= 1));

  p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (int'(push_data[KEY_W-1:0]) >= 1 && int'(push_data[KEY_W-1:0]) <= ROWS*COLS));

  p_ascend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(push_valid && push_ready) && push_valid)
      |-> (push_data[KEY_W-1:0] > $past(push_data[KEY_W-1:0])));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));

  p_no_load_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !busy);

endmodule

bind kpd_scanner kpd_scanner_chk #(.ROWS(ROWS), .COLS(COLS), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_n(row_n), .push_valid(push_valid),
  .push_ready(push_ready), .push_data(push_data), .idle(seq_idle),
  .busy(emit_busy), .scan_done(scan_done)
);

// File: tb/kpd_scanner_bench.sv
`timescale 1ns/100ps
module kpd_scanner_bench;
  localparam int ROWS    = 8;
  localparam int COLS    = 10;
  localparam int ROW_CYC = 2;
  localparam int PER     = 48;
  localparam int NK      = ROWS * COLS;
  localparam int KW      = $clog2(NK + 1);
  localparam int SCANT   = ROWS * ROW_CYC;
  localparam int LAT_HI  = 2 * PER + SCANT + 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [ROWS-1:0] row_n;
  logic [COLS-1:0] col_n;
  logic          push_valid;
  logic          push_ready = 1'b1;
  logic [KW:0]   push_data;
  logic [NK-1:0] keys = '0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [KW:0] ev_data[$];
  int          ev_cyc[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      col_n[c] = 1'b1;
      for (int r = 0; r < ROWS; r++)
        if (keys[r*COLS+c] && !row_n[r]) col_n[c] = 1'b0;
    end
  end

  kpd_scanner #(.ROWS(ROWS), .COLS(COLS), .ROW_CYC(ROW_CYC),
                .CLK_HZ(1_000_000), .SCAN_US(PER)) u_kpd_scanner (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data)
  );

  always @(negedge clk) begin
    if (rst_n && push_valid && push_ready) begin
      ev_data.push_back(push_data);
      ev_cyc.push_back(cyc);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_ev(input int n, input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (ev_data.size() >= n) break;
    end
    @(negedge clk);
  endtask

  task automatic wait_gap();
    for (int i = 0; i < 4 * PER; i++) begin
      @(negedge clk);
      if (row_n == '1) break;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    finish_run();
  end

  initial begin
    int n0;
    int t0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(push_valid == 1'b0, "R9 valid after reset", push_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(row_n == '0, "R2 rest rows low", row_n, 0);

    // Sweep every key: single press, hold, release.
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int k = r * COLS + c;
        n0 = ev_data.size();
        step();
        keys[k] = 1'b1;
        t0 = cyc;
        repeat (4) @(negedge clk);
        chk(row_n != '0, "R2 scan starts", row_n, 1);
        wait_ev(n0 + 1, LAT_HI + 8);
        if (ev_data.size() > n0) begin
          chk(ev_data[n0] == (KW+1)'(128 + k + 1), "R6 press byte", ev_data[n0], 128 + k + 1);
          chk(ev_cyc[n0] - t0 >= PER && ev_cyc[n0] - t0 <= LAT_HI, "R3 press latency",
              ev_cyc[n0] - t0, PER);
        end else chk(1'b0, "R3 press missing", 0, 1);
        repeat (3 * PER) @(negedge clk);
        chk(ev_data.size() == n0 + 1, "R10 held key single event", ev_data.size() - n0, 1);
        step();
        keys[k] = 1'b0;
        t0 = cyc;
        wait_ev(n0 + 2, LAT_HI + 8);
        if (ev_data.size() > n0 + 1) begin
          chk(ev_data[n0+1] == (KW+1)'(k + 1), "R5 release byte", ev_data[n0+1], k + 1);
          chk(ev_cyc[n0+1] - t0 >= PER && ev_cyc[n0+1] - t0 <= LAT_HI, "R5 release latency",
              ev_cyc[n0+1] - t0, PER);
        end else chk(1'b0, "R5 release missing", 0, 1);
        repeat (4) @(negedge clk);
        chk(row_n == '0, "R10 back to rest", row_n, 0);
      end
    end

    // R4: short glitch gives nothing.
    n0 = ev_data.size();
    step();
    keys[23] = 1'b1;
    repeat (10) step();
    keys[23] = 1'b0;
    repeat (4 * PER) @(negedge clk);
    chk(ev_data.size() == n0, "R4 glitch ignored", ev_data.size() - n0, 0);

    // R7: three keys in one scan, codes 45, 12, 1.
    n0 = ev_data.size();
    step();
    keys[44] = 1'b1; keys[11] = 1'b1; keys[0] = 1'b1;
    wait_ev(n0 + 3, LAT_HI + 16);
    if (ev_data.size() >= n0 + 3) begin
      chk(ev_data[n0]   == 9'h081 || 1'b0 ? ev_data[n0] == (KW+1)'(128+1) : 1'b0,
          "R7 first code 1", ev_data[n0], 129);
      chk(ev_data[n0+1] == (KW+1)'(128+12), "R7 second code 12", ev_data[n0+1], 140);
      chk(ev_data[n0+2] == (KW+1)'(128+45), "R7 third code 45", ev_data[n0+2], 173);
      chk(ev_cyc[n0+2] - ev_cyc[n0] == 2, "R7 one per clock", ev_cyc[n0+2] - ev_cyc[n0], 2);
    end else chk(1'b0, "R7 batch missing", ev_data.size() - n0, 3);

    // R7: release of 12 and press of 80 confirmed in the same scan.
    repeat (2 * PER) @(negedge clk);
    n0 = ev_data.size();
    wait_gap();
    step();
    keys[11] = 1'b0; keys[79] = 1'b1;
    wait_ev(n0 + 2, LAT_HI + 16);
    if (ev_data.size() >= n0 + 2) begin
      chk(ev_data[n0]   == (KW+1)'(12), "R7 mixed release 12", ev_data[n0], 12);
      chk(ev_data[n0+1] == (KW+1)'(128+80), "R7 mixed press 80", ev_data[n0+1], 208);
      chk(ev_cyc[n0+1] - ev_cyc[n0] == 1, "R7 mixed adjacent", ev_cyc[n0+1] - ev_cyc[n0], 1);
    end else chk(1'b0, "R7 mixed missing", ev_data.size() - n0, 2);

    // R8: back-pressure holds data, nothing lost.
    repeat (2 * PER) @(negedge clk);
    n0 = ev_data.size();
    step();
    push_ready = 1'b0;
    keys = '0;
    repeat (5 * PER) @(negedge clk);
    chk(push_valid == 1'b1, "R8 valid held", push_valid, 1);
    chk(push_data == (KW+1)'(1), "R8 data held", push_data, 1);
    chk(ev_data.size() == n0, "R8 nothing taken", ev_data.size() - n0, 0);
    step();
    push_ready = 1'b1;
    wait_ev(n0 + 3, 16);
    if (ev_data.size() >= n0 + 3) begin
      chk(ev_data[n0]   == (KW+1)'(1),  "R8 release 1", ev_data[n0], 1);
      chk(ev_data[n0+1] == (KW+1)'(45), "R8 release 45", ev_data[n0+1], 45);
      chk(ev_data[n0+2] == (KW+1)'(80), "R8 release 80", ev_data[n0+2], 80);
    end else chk(1'b0, "R8 releases missing", ev_data.size() - n0, 3);
    repeat (3 * PER) @(negedge clk);
    chk(ev_data.size() == n0 + 3, "R8 no extra events", ev_data.size() - n0, 3);
    chk(row_n == '0, "R10 rest after drain", row_n, 0);
    chk(push_valid == 1'b0, "R9 valid low when empty", push_valid, 0);

    finish_run();
  end

endmodule